// File: doc/BRIEF.md
# Lockable Remap Window Address Decoder

This block decides whether a 36-bit physical address falls inside a programmable remap window. Two 16-bit configuration registers hold the lower and upper bounds of the window. Each register stores address bits 35:26 in its low ten bits, so the window is set in 64 MB granules. The low 26 address bits of the lower bound are taken as zeros and those of the upper bound as ones. Both bounds are inclusive. The hit output is combinational from the address input and the stored bounds.

Software writes and reads the bounds through a byte-addressed register port with byte enables. A sticky lock input freezes both bound fields until the next reset. If the lower bound field is larger than the upper bound field, the window is off. The reset values give exactly that case, so no address hits out of reset.

Top module: `remap_window_decoder`

## Requirements
- R1: After reset the lower-bound register reads 03FFh, the upper-bound register reads 0000h, the lock is clear and `hit_o` is low for every address.
- R2: Bits 15:10 of both registers always read as zero, and writing ones to them has no effect.
- R3: Byte enable bit 0 updates register bits 7:0 and byte enable bit 1 updates register bits 9:8. A lane whose enable is low keeps its value.
- R4: `cfg_off_i[7:1]` selects the register and bit 0 is ignored. Offsets 98h/99h select the lower bound and 9Ah/9Bh select the upper bound. Any other offset reads zero, and a write to it changes neither register.
- R5: `hit_o` is high when lower <= `phys_addr_i[35:26]` <= upper and lower <= upper. The address {lower,26'h0} and the address {upper,26'h3FFFFFF} both hit.
- R6: The address one byte below {lower,26'h0} misses, and so does the address one byte above {upper,26'h3FFFFFF}.
- R7: While the lower field is greater than the upper field, `hit_o` stays low for every address.
- R8: A write is ignored when `lock_i` is high in that cycle or any earlier cycle since reset. The lock stays set until reset, and reset restores the defaults and clears the lock.
- R9: When the lower and upper fields are equal, exactly that one 64 MB granule hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_i | input | 1 | Lock request, held sticky inside the block |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_be_i | input | 2 | Byte enables for the write |
| cfg_off_i | input | 8 | Byte offset of the register access |
| cfg_wdata_i | input | 16 | Write data |
| cfg_rdata_o | output | 16 | Read data for `cfg_off_i`, combinational |
| phys_addr_i | input | 36 | Physical address to test |
| hit_o | output | 1 | High when the address is inside the window |

## Verification
The assertions assume that `lock_i`, `cfg_wr_i`, `cfg_be_i`, `cfg_off_i` and `phys_addr_i` are stable and known at each rising clock edge. They also assume the register state changes only at that edge. The stimulus meets this by changing every input just after the falling edge, so inputs hold steady for a half period before the rising edge. The bench compares read data and `hit_o` against a behavioural model on every clock, including while a write or lock request is being applied.

// File: rtl/remap_pkg.sv
package remap_pkg;
    parameter int ADDR_W   = 36;
    parameter int GRAN_LSB = 26;
    parameter int REG_W    = 16;
    parameter int OFF_W    = 8;
    localparam int FIELD_W = ADDR_W - GRAN_LSB;
    localparam int LANES   = (REG_W + 7) / 8;

    typedef struct packed {
        logic [FIELD_W-1:0] field;
    } field_state_t;

    typedef struct packed {
        logic locked;
    } lock_state_t;
endpackage

// File: rtl/remap_lock.sv
module remap_lock (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lock_i,
    output logic locked_o,
    output logic block_wr_o
);
    import remap_pkg::*;

    lock_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.locked = st_q.locked | lock_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign locked_o   = st_q.locked;
    assign block_wr_o = st_q.locked | lock_i;

    a_r8_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked_o |=> locked_o);
    a_r8_lock_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_i |=> locked_o);
endmodule

// File: rtl/remap_field_reg.sv
module remap_field_reg #(
    parameter int FIELD_W = remap_pkg::FIELD_W,
    parameter int REG_W   = remap_pkg::REG_W,
    parameter int LANES   = remap_pkg::LANES,
    parameter logic [FIELD_W-1:0] RST_VAL = '0
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               sel_i,
    input  logic               wr_i,
    input  logic [LANES-1:0]   be_i,
    input  logic [REG_W-1:0]   wdata_i,
    input  logic               block_i,
    output logic [FIELD_W-1:0] field_o
);
    logic [FIELD_W-1:0] field_d, field_q;
    logic [FIELD_W-1:0] lane_mask;

    always_comb begin
        for (int i = 0; i < FIELD_W; i++) begin
            lane_mask[i] = be_i[i / 8];
        end
    end

    always_comb begin
        field_d = field_q;
        if (sel_i && wr_i && !block_i) begin
            field_d = (field_q & ~lane_mask) | (wdata_i[FIELD_W-1:0] & lane_mask);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) field_q <= RST_VAL;
        else         field_q <= field_d;
    end

    assign field_o = field_q;

    a_r8_blocked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        block_i |=> $stable(field_o));
    a_r4_unselected_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_i |=> $stable(field_o));
    a_r3_lane_off_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !be_i[0] |=> $stable(field_o[7:0]));
endmodule

// File: rtl/remap_hit_cmp.sv
module remap_hit_cmp #(
    parameter int ADDR_W   = remap_pkg::ADDR_W,
    parameter int GRAN_LSB = remap_pkg::GRAN_LSB,
    parameter int FIELD_W  = ADDR_W - GRAN_LSB
) (
    input  logic [FIELD_W-1:0] lo_i,
    input  logic [FIELD_W-1:0] hi_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic               enabled_o,
    output logic               hit_o
);
    logic [FIELD_W-1:0] granule;
    logic above_lo, below_hi;

    always_comb begin
        granule   = addr_i[ADDR_W-1:GRAN_LSB];
        enabled_o = (lo_i <= hi_i);
        above_lo  = (granule >= lo_i);
        below_hi  = (granule <= hi_i);
        hit_o     = enabled_o & above_lo & below_hi;
    end
endmodule

// File: rtl/remap_window_decoder.sv
module remap_window_decoder #(
    parameter int ADDR_W   = remap_pkg::ADDR_W,
    parameter int GRAN_LSB = remap_pkg::GRAN_LSB,
    parameter int REG_W    = remap_pkg::REG_W,
    parameter int OFF_W    = remap_pkg::OFF_W,
    parameter logic [OFF_W-1:0] LO_OFF = 8'h98,
    parameter logic [OFF_W-1:0] HI_OFF = 8'h9A,
    parameter int FIELD_W  = ADDR_W - GRAN_LSB,
    parameter logic [FIELD_W-1:0] LO_RST = '1,
    parameter logic [FIELD_W-1:0] HI_RST = '0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              lock_i,
    input  logic              cfg_wr_i,
    input  logic [1:0]        cfg_be_i,
    input  logic [OFF_W-1:0]  cfg_off_i,
    input  logic [REG_W-1:0]  cfg_wdata_i,
    output logic [REG_W-1:0]  cfg_rdata_o,
    input  logic [ADDR_W-1:0] phys_addr_i,
    output logic              hit_o
);
    localparam int PAD_W = REG_W - FIELD_W;

    logic               sel_lo, sel_hi;
    logic               locked, block_wr, win_en;
    logic [FIELD_W-1:0] lo_q, hi_q;

    always_comb begin
        sel_lo = (cfg_off_i[OFF_W-1:1] == LO_OFF[OFF_W-1:1]);
        sel_hi = (cfg_off_i[OFF_W-1:1] == HI_OFF[OFF_W-1:1]);
    end

    remap_lock u_lock (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .lock_i     (lock_i),
        .locked_o   (locked),
        .block_wr_o (block_wr)
    );

    remap_field_reg #(.FIELD_W(FIELD_W), .REG_W(REG_W), .LANES(2), .RST_VAL(LO_RST)) u_lo (
        .clk_i (clk_i), .rst_ni (rst_ni), .sel_i (sel_lo), .wr_i (cfg_wr_i),
        .be_i (cfg_be_i), .wdata_i (cfg_wdata_i), .block_i (block_wr), .field_o (lo_q)
    );

    remap_field_reg #(.FIELD_W(FIELD_W), .REG_W(REG_W), .LANES(2), .RST_VAL(HI_RST)) u_hi (
        .clk_i (clk_i), .rst_ni (rst_ni), .sel_i (sel_hi), .wr_i (cfg_wr_i),
        .be_i (cfg_be_i), .wdata_i (cfg_wdata_i), .block_i (block_wr), .field_o (hi_q)
    );

    remap_hit_cmp #(.ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB), .FIELD_W(FIELD_W)) u_cmp (
        .lo_i      (lo_q),
        .hi_i      (hi_q),
        .addr_i    (phys_addr_i),
        .enabled_o (win_en),
        .hit_o     (hit_o)
    );

    always_comb begin
        cfg_rdata_o = '0;
        if (sel_lo)      cfg_rdata_o = {{PAD_W{1'b0}}, lo_q};
        else if (sel_hi) cfg_rdata_o = {{PAD_W{1'b0}}, hi_q};
    end

    a_r7_off_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lo_q > hi_q) |-> !hit_o);
    a_r5_hit_in_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> (phys_addr_i[ADDR_W-1:GRAN_LSB] >= lo_q && phys_addr_i[ADDR_W-1:GRAN_LSB] <= hi_q));
    a_r4_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_wr_i && !sel_lo && !sel_hi) |=> ($stable(lo_q) && $stable(hi_q)));
    a_r8_locked_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked |=> ($stable(lo_q) && $stable(hi_q)));
    a_r7_enable_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !win_en |-> !hit_o);
endmodule

// File: tb/sim_remap_window_decoder.sv
`timescale 1ns/1ps
module sim_remap_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  be = 2'b00;
    logic [7:0]  off = 8'h00;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] rdata;
    logic [35:0] addr = 36'h0;
    logic        hit;

    int n_cmp = 0;
    int n_bad = 0;
    int m_lo, m_hi;
    bit m_lock;

    always #10 clk = ~clk;

    remap_window_decoder u0 (
        .clk_i (clk), .rst_ni (rst_n), .lock_i (lock), .cfg_wr_i (wr),
        .cfg_be_i (be), .cfg_off_i (off), .cfg_wdata_i (wdata),
        .cfg_rdata_o (rdata), .phys_addr_i (addr), .hit_o (hit)
    );

    function automatic int model_read(input logic [7:0] o);
        if (o[7:1] == 7'h4C) return m_lo;
        if (o[7:1] == 7'h4D) return m_hi;
        return 0;
    endfunction

    function automatic bit model_hit(input logic [35:0] a);
        int g;
        g = int'(a[35:26]);
        return (m_lo <= m_hi) && (g >= m_lo) && (g <= m_hi);
    endfunction

    function automatic int merge(input int old, input logic [1:0] b, input logic [15:0] d);
        int v;
        v = old;
        if (b[0]) v = (v & 32'h300) | int'(d[7:0]);
        if (b[1]) v = (v & 32'h0FF) | (int'(d[9:8]) << 8);
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr = 1'b0; lock = 1'b0;
        m_lo = 'h3FF; m_hi = 0; m_lock = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cyc(input bit w, input logic [1:0] b, input logic [7:0] o,
                       input logic [15:0] d, input bit lk, input logic [35:0] a,
                       input string rq);
        int exp_rd;
        bit exp_hit;
        @(negedge clk);
        wr = w; be = b; off = o; wdata = d; lock = lk; addr = a;
        #2;
        exp_rd  = model_read(o);
        exp_hit = model_hit(a);
        n_cmp++;
        if (int'(rdata) != exp_rd) begin
            n_bad++;
            $display("FAIL %s rdata off=%h actual=%h expected=%h", rq, o, rdata, exp_rd[15:0]);
        end
        n_cmp++;
        if (hit != exp_hit) begin
            n_bad++;
            $display("FAIL %s hit addr=%h actual=%0d expected=%0d", rq, a, hit, exp_hit);
        end
        if (w && !m_lock && !lk) begin
            if (o[7:1] == 7'h4C) m_lo = merge(m_lo, b, d);
            if (o[7:1] == 7'h4D) m_hi = merge(m_hi, b, d);
        end
        if (lk) m_lock = 1'b1;
    endtask

    task automatic rd(input logic [7:0] o, input logic [35:0] a, input string rq);
        cyc(1'b0, 2'b00, o, 16'h0, 1'b0, a, rq);
    endtask

    task automatic wrr(input logic [7:0] o, input logic [1:0] b, input logic [15:0] d, input string rq);
        cyc(1'b1, b, o, d, 1'b0, 36'h0, rq);
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 defaults and window off
        rd(8'h98, {10'h3FF, 26'h0}, "R1");
        rd(8'h9A, {10'h000, 26'h0}, "R1");
        rd(8'h99, 36'hF_FFFF_FFFF, "R7");
        // R2 reserved bits ignored
        wrr(8'h98, 2'b11, 16'hFC10, "R2");
        rd(8'h98, 36'h0, "R2");
        // R3 byte lanes
        wrr(8'h9A, 2'b01, 16'hFF20, "R3");
        rd(8'h9A, 36'h0, "R3");
        wrr(8'h9B, 2'b10, 16'h0100, "R3");
        rd(8'h9A, 36'h0, "R3");
        wrr(8'h9A, 2'b11, 16'h0020, "R3");
        // R5 and R6 bounds
        rd(8'h98, {10'h010, 26'h0}, "R5");
        rd(8'h9A, {10'h020, 26'h3FFFFFF}, "R5");
        rd(8'h98, {10'h018, 26'h1234567}, "R5");
        rd(8'h98, {10'h00F, 26'h3FFFFFF}, "R6");
        rd(8'h9A, {10'h021, 26'h0}, "R6");
        // R4 stray offsets
        wrr(8'h9C, 2'b11, 16'h03FF, "R4");
        rd(8'h9C, 36'h0, "R4");
        rd(8'h98, 36'h0, "R4");
        rd(8'h9A, 36'h0, "R4");
        wrr(8'h96, 2'b11, 16'h0000, "R4");
        rd(8'h98, 36'h0, "R4");
        // R9 single granule
        wrr(8'h98, 2'b11, 16'h0100, "R9");
        wrr(8'h9A, 2'b11, 16'h0100, "R9");
        rd(8'h98, {10'h100, 26'h0}, "R9");
        rd(8'h98, {10'h100, 26'h3FFFFFF}, "R9");
        rd(8'h98, {10'h0FF, 26'h3FFFFFF}, "R9");
        rd(8'h98, {10'h101, 26'h0}, "R9");
        // R7 lower above upper
        wrr(8'h98, 2'b11, 16'h0200, "R7");
        wrr(8'h9A, 2'b11, 16'h01FF, "R7");
        rd(8'h98, {10'h200, 26'h0}, "R7");
        rd(8'h9A, {10'h1FF, 26'h3FFFFFF}, "R7");
        // R8 lock
        wrr(8'h98, 2'b11, 16'h0050, "R8");
        wrr(8'h9A, 2'b11, 16'h0060, "R8");
        cyc(1'b1, 2'b11, 8'h98, 16'h0001, 1'b1, {10'h050, 26'h0}, "R8");
        rd(8'h98, {10'h050, 26'h0}, "R8");
        wrr(8'h98, 2'b11, 16'h0002, "R8");
        wrr(8'h9A, 2'b01, 16'h00FF, "R8");
        rd(8'h98, {10'h060, 26'h3FFFFFF}, "R8");
        rd(8'h9A, {10'h061, 26'h0}, "R8");
        // R8 reset clears lock, R1 defaults return
        do_reset();
        rd(8'h98, 36'h0, "R1");
        rd(8'h9A, 36'h0, "R1");
        wrr(8'h9A, 2'b11, 16'h03FF, "R8");
        wrr(8'h98, 2'b11, 16'h0000, "R8");
        rd(8'h9A, 36'h0, "R8");
        rd(8'h98, 36'hF_FFFF_FFFF, "R5");
        rd(8'h98, 36'h0, "R5");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule